// File: doc/BRIEF.md
# Multiplexed Serial ADC Host Controller

This block drives a 12-bit serial analog-to-digital converter that selects one of several inputs through an internal multiplexer and signals conversion completion on a separate end-of-conversion line. A client hands the controller a 4-bit channel number and a 4-bit control nibble through a valid/ready request. The controller then lowers chip select and runs one frame of twelve serial clock cycles, derived from the system clock by a divider. In that frame it sends the 8-bit command MSB first and collects twelve result bits.

The converter pipelines its work. The word that comes back in a frame belongs to the conversion requested in the frame before it. For this reason the controller tags every result with the channel of the previous frame. It clears the tag-valid bit when no completed previous conversion exists, which covers the first frame after reset and the frame that follows a timeout. After each frame the controller waits for end-of-conversion to go high again before it accepts another request. If that edge does not arrive within a set number of cycles, it raises an error flag.

Top module: `serial_adc_host`

## Requirements
- R1: A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high, and `adc_cs_no` is low from that edge on. `req_ready_o` is high only while the controller is idle with chip select high.
- R2: `adc_sclk_o` is low whenever chip select is high. A frame holds exactly 12 rising and 12 falling serial clock edges, each half period lasting HALF_DIV system clocks. The first rising edge comes HALF_DIV clocks after the accepting edge.
- R3: The command is {channel[3:0], control[3:0]}. It is presented MSB first on `adc_mosi_o` and is stable at each of the first 8 rising serial clock edges. `adc_mosi_o` is 0 at rising edges 9 to 12.
- R4: `adc_miso_i` is sampled at each rising serial clock edge. The first sample, which the converter drives from the chip-select fall, becomes bit 11 of `res_data_o`, and the later samples fill the lower bits in order.
- R5: Chip select returns high HALF_DIV clocks after the 12th falling edge. `res_valid_o` pulses for exactly one cycle in the same cycle, 25*HALF_DIV clock edges after the accepting edge.
- R6: `res_chan_o` carries the channel sent in the previous frame. `res_tag_ok_o` is 1 when that previous frame completed its end-of-conversion handshake.
- R7: The first result after reset, including a reset in the middle of a frame, has `res_tag_ok_o` = 0.
- R8: After a frame, `req_ready_o` rises on the second clock edge after `adc_eoc_i` goes high, and not earlier. End-of-conversion passes through one synchronizing flop before edge detection.
- R9: No new request is accepted between the accepting edge and the end of the wait: `req_ready_o` stays low for that whole interval.
- R10: If no rising end-of-conversion is seen within EOC_TIMEOUT clocks of entering the wait, `eoc_err_o` goes high on that clock and the controller becomes idle. The next result has `res_tag_ok_o` = 0, and `eoc_err_o` clears on the next accepted request.
- R11: Under reset: `adc_cs_no`=1, `adc_sclk_o`=0, `req_ready_o`=1, `res_valid_o`=0, `eoc_err_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Conversion request present |
| req_ready_o | output | 1 | Controller can take a request |
| req_chan_i | input | 4 | Multiplexer channel to convert |
| req_ctrl_i | input | 4 | Control nibble sent after the channel |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_data_o | output | 12 | Result word from the frame just ended |
| res_chan_o | output | 4 | Channel the result belongs to |
| res_tag_ok_o | output | 1 | Result corresponds to a completed conversion |
| eoc_err_o | output | 1 | End-of-conversion timeout flag |
| adc_cs_no | output | 1 | Converter chip select, active low |
| adc_sclk_o | output | 1 | Serial clock to the converter |
| adc_mosi_o | output | 1 | Command bit to the converter |
| adc_miso_i | input | 1 | Result bit from the converter |
| adc_eoc_i | input | 1 | Converter end-of-conversion, high when ready |

## Verification
The bench counts clock edges from the accepting edge. The first serial rise is due HALF_DIV edges later and the result strobe 25*HALF_DIV edges later. Ready is due exactly two edges after end-of-conversion rises, and the error flag exactly EOC_TIMEOUT edges after the result strobe when end-of-conversion stalls. A converter model in the bench records every serial edge at the falling system clock. The main sequence samples one nanosecond after that falling edge, so each check reads values from a known cycle count and never at an edge. Both the cycle before and the cycle of each due event are checked, which catches results that arrive early as well as late.

// File: rtl/serial_adc_host_pkg.sv
package serial_adc_host_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_HOLD,
    ST_WAIT
  } host_state_e;

endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic toggle_i,
  output logic tick_o,
  output logic rise_o,
  output logic fall_o,
  output logic sclk_o
);

  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CW'(HALF_DIV - 1));
  assign rise_o = tick_o && toggle_i && !sclk_o;
  assign fall_o = tick_o && toggle_i && sclk_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_o <= 1'b0;
    end else begin
      if (!run_i || tick_o) cnt_q <= '0;
      else                  cnt_q <= cnt_q + 1'b1;
      if (!toggle_i)        sclk_o <= 1'b0;
      else if (tick_o)      sclk_o <= !sclk_o;
    end
  end

  AST_SCLK_HOLDS_BETWEEN_TICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && toggle_i && !tick_o |=> $stable(sclk_o)); // R2

endmodule

// File: rtl/adc_frame_shifter.sv
module adc_frame_shifter #(
  parameter int unsigned CMD_W      = 8,
  parameter int unsigned DATA_W     = 12,
  parameter int unsigned FRAME_BITS = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [DATA_W-1:0] data_o,
  output logic              last_fall_o
);

  localparam int unsigned BW = $clog2(FRAME_BITS + 1);

  logic [CMD_W-1:0] cmd_q;
  logic [BW-1:0]    bit_q;

  assign mosi_o      = cmd_q[CMD_W-1];
  assign last_fall_o = fall_i && (bit_q == BW'(FRAME_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      bit_q  <= '0;
      data_o <= '0;
    end else if (load_i) begin
      cmd_q <= cmd_i;
      bit_q <= '0;
    end else begin
      if (fall_i) begin
        cmd_q <= {cmd_q[CMD_W-2:0], 1'b0};
        bit_q <= bit_q + 1'b1;
      end
      if (rise_i) data_o <= {data_o[DATA_W-2:0], miso_i};
    end
  end

  AST_BIT_COUNT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_q <= BW'(FRAME_BITS)); // R2
  AST_MOSI_ZERO_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i && (bit_q >= BW'(CMD_W)) |-> !mosi_o); // R3

endmodule

// File: rtl/adc_eoc_watch.sv
module adc_eoc_watch #(
  parameter int unsigned TIMEOUT = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic eoc_i,
  output logic done_o,
  output logic timeout_o
);

  localparam int unsigned TW = $clog2(TIMEOUT + 1);

  logic          eoc_s_q, eoc_d_q;
  logic [TW-1:0] tcnt_q;

  assign done_o    = arm_i && eoc_s_q && !eoc_d_q;
  assign timeout_o = arm_i && !done_o && (tcnt_q == TW'(TIMEOUT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eoc_s_q <= 1'b1;
      eoc_d_q <= 1'b1;
      tcnt_q  <= '0;
    end else begin
      eoc_s_q <= eoc_i;
      eoc_d_q <= eoc_s_q;
      if (!arm_i) tcnt_q <= '0;
      else        tcnt_q <= tcnt_q + 1'b1;
    end
  end

  AST_TIMER_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |-> tcnt_q < TW'(TIMEOUT)); // R10

endmodule

// File: rtl/serial_adc_host.sv
module serial_adc_host
  import serial_adc_host_pkg::*;
#(
  parameter int unsigned HALF_DIV    = 4,
  parameter int unsigned EOC_TIMEOUT = 4096,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned CTRL_W      = 4,
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned FRAME_BITS  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_chan_i,
  input  logic [CTRL_W-1:0] req_ctrl_i,
  output logic              res_valid_o,
  output logic [DATA_W-1:0] res_data_o,
  output logic [ADDR_W-1:0] res_chan_o,
  output logic              res_tag_ok_o,
  output logic              eoc_err_o,
  output logic              adc_cs_no,
  output logic              adc_sclk_o,
  output logic              adc_mosi_o,
  input  logic              adc_miso_i,
  input  logic              adc_eoc_i
);

  localparam int unsigned CMD_W = ADDR_W + CTRL_W;

  host_state_e       state_q;
  logic [ADDR_W-1:0] cur_chan_q, prev_chan_q;
  logic              prev_ok_q;
  logic              accept, run, toggle, tick, rise, fall, last_fall;
  logic              eoc_done, eoc_to;
  logic [DATA_W-1:0] shift_data;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign run         = (state_q == ST_SHIFT) || (state_q == ST_HOLD);
  assign toggle      = (state_q == ST_SHIFT);

  adc_sclk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .toggle_i (toggle),
    .tick_o   (tick),
    .rise_o   (rise),
    .fall_o   (fall),
    .sclk_o   (adc_sclk_o)
  );

  adc_frame_shifter #(
    .CMD_W      (CMD_W),
    .DATA_W     (DATA_W),
    .FRAME_BITS (FRAME_BITS)
  ) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (accept),
    .cmd_i       ({req_chan_i, req_ctrl_i}),
    .rise_i      (rise),
    .fall_i      (fall),
    .miso_i      (adc_miso_i),
    .mosi_o      (adc_mosi_o),
    .data_o      (shift_data),
    .last_fall_o (last_fall)
  );

  adc_eoc_watch #(.TIMEOUT(EOC_TIMEOUT)) u_eoc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (state_q == ST_WAIT),
    .eoc_i     (adc_eoc_i),
    .done_o    (eoc_done),
    .timeout_o (eoc_to)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      adc_cs_no    <= 1'b1;
      res_valid_o  <= 1'b0;
      res_data_o   <= '0;
      res_chan_o   <= '0;
      res_tag_ok_o <= 1'b0;
      eoc_err_o    <= 1'b0;
      cur_chan_q   <= '0;
      prev_chan_q  <= '0;
      prev_ok_q    <= 1'b0;
    end else begin
      res_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q    <= ST_SHIFT;
          adc_cs_no  <= 1'b0;
          eoc_err_o  <= 1'b0;
          cur_chan_q <= req_chan_i;
        end
        ST_SHIFT: if (last_fall) state_q <= ST_HOLD;
        ST_HOLD: if (tick) begin
          // result word carries the previous frame's channel
          state_q      <= ST_WAIT;
          adc_cs_no    <= 1'b1;
          res_valid_o  <= 1'b1;
          res_data_o   <= shift_data;
          res_chan_o   <= prev_chan_q;
          res_tag_ok_o <= prev_ok_q;
          prev_chan_q  <= cur_chan_q;
          prev_ok_q    <= 1'b0;
        end
        ST_WAIT: begin
          if (eoc_done) begin
            prev_ok_q <= 1'b1;
            state_q   <= ST_IDLE;
          end else if (eoc_to) begin
            eoc_err_o <= 1'b1;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_CS_FALLS_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> $fell(adc_cs_no)); // R1
  AST_READY_ONLY_CS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> adc_cs_no); // R9
  AST_SCLK_LOW_CS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_cs_no |-> !adc_sclk_o); // R2
  AST_RES_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o); // R5
  AST_RES_WITH_CS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $rose(adc_cs_no)); // R5

endmodule

// File: tb/serial_adc_host_bench.sv
`timescale 1ns/1ps
module serial_adc_host_bench;

  localparam int H    = 2;
  localparam int TO   = 40;
  localparam int CONV = 12;
  localparam logic [7:0] VEC [0:5] = '{8'h3A, 8'h05, 8'hA7, 8'h9C, 8'h61, 8'hF0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [3:0] req_chan = '0, req_ctrl = '0;
  logic res_valid, res_tag_ok, err, cs_n, sclk, mosi;
  logic [11:0] res_data;
  logic [3:0] res_chan;
  logic miso = 1'b0, eoc = 1'b1;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit hang = 0;

  // converter model state
  logic [11:0] slave_word = 12'hABC, word_sent = '0;
  logic [7:0]  slave_cmd = '0;
  int rise_n = 0, fall_n = 0, first_rise_cyc = -1;
  int eoc_fall_at = -1, eoc_rise_at = -1, eoc_rise_cyc = -1;
  bit tail_bad = 0;
  logic cs_prev = 1'b1, sclk_prev = 1'b0;

  // bench tag tracking
  logic [3:0] prev_chan_b = '0;
  bit prev_ok_b = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serial_adc_host #(.HALF_DIV(H), .EOC_TIMEOUT(TO)) u_serial_adc_host (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_chan_i(req_chan), .req_ctrl_i(req_ctrl),
    .res_valid_o(res_valid), .res_data_o(res_data), .res_chan_o(res_chan),
    .res_tag_ok_o(res_tag_ok), .eoc_err_o(err),
    .adc_cs_no(cs_n), .adc_sclk_o(sclk), .adc_mosi_o(mosi),
    .adc_miso_i(miso), .adc_eoc_i(eoc)
  );

  function automatic logic [11:0] word_of(input logic [3:0] c);
    return {c, ~c, c ^ 4'h9};
  endfunction

  always @(negedge clk) begin
    if (!cs_n && cs_prev) begin
      rise_n = 0; fall_n = 0; tail_bad = 0; first_rise_cyc = -1; eoc_rise_cyc = -1;
      word_sent = slave_word;
      miso = slave_word[11];
    end else if (!cs_n) begin
      if (sclk && !sclk_prev) begin
        if (rise_n == 0) first_rise_cyc = cyc;
        if (rise_n < 8) slave_cmd[7-rise_n] = mosi;
        else if (mosi) tail_bad = 1;
        rise_n++;
      end
      if (!sclk && sclk_prev) begin
        fall_n++;
        if (fall_n < 12) miso = slave_word[11-fall_n];
        if (fall_n == 12) begin
          slave_word = word_of(slave_cmd[7:4]);
          eoc_fall_at = cyc + 2;
        end
      end
    end
    if (eoc_fall_at == cyc) begin
      eoc = 1'b0;
      if (!hang) eoc_rise_at = cyc + CONV;
    end
    if (eoc_rise_at == cyc) begin
      eoc = 1'b1;
      eoc_rise_cyc = cyc;
    end
    cs_prev = cs_n;
    sclk_prev = sclk;
  end

  task automatic chk_eq(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
    #1;
  endtask

  task automatic do_frame(input logic [3:0] ch, input logic [3:0] ct);
    int t0, tv;
    step;
    while (!req_ready) step;
    req_chan = ch; req_ctrl = ct; req_valid = 1'b1;
    t0 = cyc;
    step;
    req_valid = 1'b0;
    chk_eq("R1 cs low after accept", int'(cs_n), 0);
    chk_eq("R10 err clear after accept", int'(err), 0);
    chk_eq("R9 ready low in frame", int'(req_ready), 0);
    while (!res_valid) step;
    tv = cyc;
    chk_eq("R5 result latency", tv - t0, 1 + 25*H);
    chk_eq("R5 cs high with result", int'(cs_n), 1);
    chk_eq("R2 first rise delay", first_rise_cyc - t0, 1 + H);
    chk_eq("R2 rising edge count", rise_n, 12);
    chk_eq("R2 falling edge count", fall_n, 12);
    chk_eq("R3 command bits", int'(slave_cmd), int'({ch, ct}));
    chk_eq("R3 mosi zero tail", int'(tail_bad), 0);
    chk_eq("R4 result data", int'(res_data), int'(word_sent));
    chk_eq("R6 tag valid", int'(res_tag_ok), int'(prev_ok_b));
    if (prev_ok_b) begin
      chk_eq("R6 result channel", int'(res_chan), int'(prev_chan_b));
      chk_eq("R4 data of previous channel", int'(res_data), int'(word_of(prev_chan_b)));
    end
    chk_eq("R9 ready low at result", int'(req_ready), 0);
    step;
    chk_eq("R5 result one cycle", int'(res_valid), 0);
    prev_chan_b = ch;
    prev_ok_b = !hang;
    if (!hang) begin
      while (eoc_rise_cyc < 0) begin
        if (req_ready) chk_eq("R9 ready low before eoc", 1, 0);
        step;
      end
      step;
      chk_eq("R8 ready not early", int'(req_ready), 0);
      step;
      chk_eq("R8 ready after eoc", int'(req_ready), 1);
    end
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end

  initial begin
    int tv;
    repeat (3) step;
    // R11 reset state
    chk_eq("R11 cs high", int'(cs_n), 1);
    chk_eq("R11 sclk low", int'(sclk), 0);
    chk_eq("R11 ready high", int'(req_ready), 1);
    chk_eq("R11 no result", int'(res_valid), 0);
    chk_eq("R11 err low", int'(err), 0);
    rst_n = 1'b1;
    step;

    // R7 first frame carries no tag; table walk covers R1-style framing
    for (int i = 0; i < 6; i++) do_frame(VEC[i][7:4], VEC[i][3:0]);

    // R10 end-of-conversion timeout
    hang = 1;
    do_frame(4'h7, 4'h2);
    tv = cyc - 1;
    while (cyc < tv + TO - 1) step;
    chk_eq("R10 err not early", int'(err), 0);
    step;
    chk_eq("R10 err on timeout", int'(err), 1);
    chk_eq("R10 idle after timeout", int'(req_ready), 1);
    hang = 0;
    eoc_rise_at = cyc + 1;
    step; step;
    chk_eq("R10 err held while idle", int'(err), 1);
    do_frame(4'h2, 4'h8);
    do_frame(4'hB, 4'h4);

    // R11 / R7 reset in the middle of a frame
    step;
    while (!req_ready) step;
    req_chan = 4'h5; req_ctrl = 4'h1; req_valid = 1'b1;
    step;
    req_valid = 1'b0;
    repeat (10) step;
    rst_n = 1'b0;
    step;
    chk_eq("R11 cs high in reset", int'(cs_n), 1);
    chk_eq("R11 sclk low in reset", int'(sclk), 0);
    chk_eq("R11 ready in reset", int'(req_ready), 1);
    chk_eq("R11 err low in reset", int'(err), 0);
    rst_n = 1'b1;
    prev_ok_b = 0;
    step;
    do_frame(4'hC, 4'h3);
    do_frame(4'h1, 4'hE);
    finish_run;
  end

endmodule